// File: doc/BRIEF.md
# Two-Level Cache Miss Accounting

This block models the tag directories of a two-level cache hierarchy and counts misses at each level. The first level is split into an instruction directory and a data directory. Both feed one shared second-level directory. Each incoming reference gives a byte address, an access size and a select bit that picks the instruction or the data side. The reference is looked up in the chosen first-level directory. Only when that lookup misses is the same address and size presented to the second level. No data is held or moved; only tags, valid bits and recency order are kept.

References arrive on a valid/ready stream. The block takes one reference at a time. It raises ready again only when every lookup that reference needs has completed, so directory and counter updates follow arrival order. A sender may hold valid high for any length of time. A transfer happens on any rising clock edge where both valid and ready are high. A reference that would cover more than two lines at either level is refused with a one-cycle error pulse. It is neither looked up nor counted.

The geometry of each level is set by parameters: sets, ways and line size, each a power of two, with at least two sets.

Top module: `cache_miss_acct`

## Requirements
- R1: `ref_ready` is high exactly when no reference is being processed. A reference is taken on a rising edge with `ref_valid` and `ref_ready` both high. After a non-error reference is taken, `ref_ready` stays low until all of its lookups are done.
- R2: `ref_is_instr` = 1 selects the instruction first-level directory and 0 selects the data directory. The two directories hold separate contents.
- R3: A first-level miss adds exactly 1 to `l1_miss_cnt` and sends the same address and size to the second level. A first-level hit leaves both counters unchanged.
- R4: A second-level miss adds exactly 1 to `l2_miss_cnt`. A second-level hit changes nothing.
- R5: A reference whose bytes cross into the next line is looked up on both lines. It adds at most 1 to each counter, even when both lines miss.
- R6: Each set keeps its ways in recency order. A hit moves that line to most recent. A miss installs the line as most recent and drops the least recent one.
- R7: A size of 0 is treated as a one-byte access.
- R8: A reference that spans more than two lines at either level sets `ref_err` high for one cycle, starting in the cycle after it is taken. It changes no counter and no directory entry, and `ref_ready` stays high.
- R9: Reset clears both 64-bit counters and invalidates every directory entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ref_valid | input | 1 | Reference offered |
| ref_ready | output | 1 | Block can take a reference |
| ref_addr | input | ADDR_W | Byte address of the first byte |
| ref_size | input | SIZE_W | Access size in bytes (0 treated as 1) |
| ref_is_instr | input | 1 | 1 = instruction side, 0 = data side |
| ref_err | output | 1 | One-cycle pulse: reference refused |
| l1_miss_cnt | output | CNT_W | First-level miss count |
| l2_miss_cnt | output | CNT_W | Second-level miss count |

## Verification
The hardest case to reach is an eviction that depends on recency order. To see it, a set must be filled, one older entry must be hit so that it is promoted, and then a third line must land in the same set. The stimulus builds this up step by step from the data side's set 0. It then shows the promoted line surviving and the unpromoted line being lost. A refused reference on the instruction side is followed by a single-byte access to the same line. That access must still miss, which shows the refused reference left the directory untouched.

// File: rtl/cache_miss_acct_pkg.sv
package cache_miss_acct_pkg;
  typedef enum logic [2:0] {
    WALK_IDLE,
    WALK_L1_LO,
    WALK_L1_HI,
    WALK_L2_LO,
    WALK_L2_HI
  } walk_t;
endpackage

// File: rtl/cma_span.sv
// Splits a byte range into first and last line numbers for one geometry.
module cma_span #(
  parameter int ADDR_W     = 16,
  parameter int SIZE_W     = 6,
  parameter int LINE_BYTES = 16,
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFS_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic [LINE_W-1:0] first_line,
  output logic [LINE_W-1:0] last_line,
  output logic              two_lines,
  output logic              too_wide
);
  logic [ADDR_W-1:0] extent;
  logic [ADDR_W-1:0] end_addr;
  logic [LINE_W-1:0] gap;

  always_comb begin
    extent = (size == '0) ? '0 : ADDR_W'(size) - ADDR_W'(1);
    end_addr = addr + extent;
    first_line = addr[ADDR_W-1:OFS_W];
    last_line  = end_addr[ADDR_W-1:OFS_W];
    gap        = last_line - first_line;
    two_lines  = (gap == LINE_W'(1));
    too_wide   = (gap > LINE_W'(1));
  end
endmodule

// File: rtl/cma_dir.sv
// Set-associative tag directory with recency-ordered ways (way 0 = most recent).
module cma_dir #(
  parameter int ADDR_W     = 16,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int LINE_BYTES = 16,
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int SET_W     = $clog2(SETS),
  localparam int LINE_W    = ADDR_W - OFS_W,
  localparam int TAG_W     = LINE_W - SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_en,
  input  logic [LINE_W-1:0] lk_line,
  output logic              hit
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag_in;
  logic [WAYS-1:0]  match;
  int               shift_top;

  assign set_idx = lk_line[SET_W-1:0];
  assign tag_in  = lk_line[LINE_W-1:SET_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld_q[set_idx][w] && (tag_q[set_idx][w] == tag_in);
  end

  assign hit = |match;

  // Highest way that shifts down by one: the matching way, or the last way on a miss.
  always_comb begin
    shift_top = WAYS - 1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) shift_top = w;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_en) begin
      tag_q[set_idx][0] <= tag_in;
      for (int j = 1; j < WAYS; j++) begin
        if (j <= shift_top) tag_q[set_idx][j] <= tag_q[set_idx][j-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (lk_en) begin
      vld_q[set_idx][0] <= 1'b1;
      for (int j = 1; j < WAYS; j++) begin
        if (j <= shift_top) vld_q[set_idx][j] <= vld_q[set_idx][j-1];
      end
    end
  end
endmodule

// File: rtl/cache_miss_acct.sv
module cache_miss_acct
  import cache_miss_acct_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SIZE_W   = 6,
  parameter int L1_SETS  = 4,
  parameter int L1_WAYS  = 2,
  parameter int L1_LINE  = 16,
  parameter int L2_SETS  = 8,
  parameter int L2_WAYS  = 4,
  parameter int L2_LINE  = 32,
  parameter int CNT_W    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_valid,
  output logic              ref_ready,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic [SIZE_W-1:0] ref_size,
  input  logic              ref_is_instr,
  output logic              ref_err,
  output logic [CNT_W-1:0]  l1_miss_cnt,
  output logic [CNT_W-1:0]  l2_miss_cnt
);
  localparam int L1_LW = ADDR_W - $clog2(L1_LINE);
  localparam int L2_LW = ADDR_W - $clog2(L2_LINE);

  walk_t            st_q;
  logic             miss_q, err_q, instr_q;
  logic [L1_LW-1:0] l1_lo_q, l1_hi_q, l1_lo, l1_hi, l1_line;
  logic [L2_LW-1:0] l2_lo_q, l2_hi_q, l2_lo, l2_hi, l2_line;
  logic             l1_two_q, l2_two_q, l1_two, l2_two, l1_wide, l2_wide;
  logic [1:0]       l1_hit_side;
  logic             l1_hit, l2_hit, l1_phase, l2_phase;
  logic [CNT_W-1:0] l1_cnt_q, l2_cnt_q;

  cma_span #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(L1_LINE)) u_span1 (
    .addr(ref_addr), .size(ref_size), .first_line(l1_lo), .last_line(l1_hi),
    .two_lines(l1_two), .too_wide(l1_wide));

  cma_span #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(L2_LINE)) u_span2 (
    .addr(ref_addr), .size(ref_size), .first_line(l2_lo), .last_line(l2_hi),
    .two_lines(l2_two), .too_wide(l2_wide));

  assign l1_phase = (st_q == WALK_L1_LO) || (st_q == WALK_L1_HI);
  assign l2_phase = (st_q == WALK_L2_LO) || (st_q == WALK_L2_HI);
  assign l1_line  = (st_q == WALK_L1_HI) ? l1_hi_q : l1_lo_q;
  assign l2_line  = (st_q == WALK_L2_HI) ? l2_hi_q : l2_lo_q;

  // Side 0 = data, side 1 = instruction.
  for (genvar g = 0; g < 2; g++) begin : g_l1
    cma_dir #(.ADDR_W(ADDR_W), .SETS(L1_SETS), .WAYS(L1_WAYS), .LINE_BYTES(L1_LINE)) u_dir (
      .clk(clk), .rst(rst),
      .lk_en(l1_phase && (instr_q == (g == 1))),
      .lk_line(l1_line), .hit(l1_hit_side[g]));
  end
  assign l1_hit = l1_hit_side[instr_q];

  cma_dir #(.ADDR_W(ADDR_W), .SETS(L2_SETS), .WAYS(L2_WAYS), .LINE_BYTES(L2_LINE)) u_l2 (
    .clk(clk), .rst(rst), .lk_en(l2_phase), .lk_line(l2_line), .hit(l2_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= WALK_IDLE;
      miss_q   <= 1'b0;
      err_q    <= 1'b0;
      instr_q  <= 1'b0;
      l1_lo_q  <= '0;
      l1_hi_q  <= '0;
      l2_lo_q  <= '0;
      l2_hi_q  <= '0;
      l1_two_q <= 1'b0;
      l2_two_q <= 1'b0;
      l1_cnt_q <= '0;
      l2_cnt_q <= '0;
    end else begin
      err_q <= 1'b0;
      unique case (st_q)
        WALK_IDLE: if (ref_valid) begin
          if (l1_wide || l2_wide) begin
            err_q <= 1'b1;
          end else begin
            instr_q  <= ref_is_instr;
            l1_lo_q  <= l1_lo;
            l1_hi_q  <= l1_hi;
            l2_lo_q  <= l2_lo;
            l2_hi_q  <= l2_hi;
            l1_two_q <= l1_two;
            l2_two_q <= l2_two;
            miss_q   <= 1'b0;
            st_q     <= WALK_L1_LO;
          end
        end
        WALK_L1_LO: begin
          if (l1_two_q) begin
            miss_q <= !l1_hit;
            st_q   <= WALK_L1_HI;
          end else if (!l1_hit) begin
            l1_cnt_q <= l1_cnt_q + CNT_W'(1);
            st_q     <= WALK_L2_LO;
          end else begin
            st_q <= WALK_IDLE;
          end
        end
        WALK_L1_HI: begin
          if (miss_q || !l1_hit) begin
            l1_cnt_q <= l1_cnt_q + CNT_W'(1);
            miss_q   <= 1'b0;
            st_q     <= WALK_L2_LO;
          end else begin
            st_q <= WALK_IDLE;
          end
        end
        WALK_L2_LO: begin
          if (l2_two_q) begin
            miss_q <= !l2_hit;
            st_q   <= WALK_L2_HI;
          end else begin
            if (!l2_hit) l2_cnt_q <= l2_cnt_q + CNT_W'(1);
            st_q <= WALK_IDLE;
          end
        end
        WALK_L2_HI: begin
          if (miss_q || !l2_hit) l2_cnt_q <= l2_cnt_q + CNT_W'(1);
          miss_q <= 1'b0;
          st_q   <= WALK_IDLE;
        end
        default: st_q <= WALK_IDLE;
      endcase
    end
  end

  assign ref_ready   = (st_q == WALK_IDLE);
  assign ref_err     = err_q;
  assign l1_miss_cnt = l1_cnt_q;
  assign l2_miss_cnt = l2_cnt_q;
endmodule

// File: rtl/cache_miss_acct_chk.sv
module cache_miss_acct_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_valid,
  input logic             ref_ready,
  input logic             ref_err,
  input logic [CNT_W-1:0] l1_miss_cnt,
  input logic [CNT_W-1:0] l2_miss_cnt
);
  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (rst)
    (ref_valid && ref_ready) |=> (!ref_ready || ref_err));

  p_l1_single_step_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((l1_miss_cnt == $past(l1_miss_cnt)) ||
              (l1_miss_cnt == $past(l1_miss_cnt) + CNT_W'(1))));

  p_l2_single_step_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((l2_miss_cnt == $past(l2_miss_cnt)) ||
              (l2_miss_cnt == $past(l2_miss_cnt) + CNT_W'(1))));

  // R4: the second level is only reached through first-level misses.
  p_l2_bounded_r4: assert property (@(posedge clk) disable iff (rst)
    l2_miss_cnt <= l1_miss_cnt);

  p_err_no_count_r8: assert property (@(posedge clk) disable iff (rst)
    ref_err |-> ($stable(l1_miss_cnt) && $stable(l2_miss_cnt)));

  p_err_stays_ready_r8: assert property (@(posedge clk) disable iff (rst)
    ref_err |-> ref_ready);
endmodule

bind cache_miss_acct cache_miss_acct_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_ready(ref_ready),
  .ref_err(ref_err), .l1_miss_cnt(l1_miss_cnt), .l2_miss_cnt(l2_miss_cnt));

// File: tb/cache_miss_acct_test.sv
`timescale 1ns/1ps
module cache_miss_acct_test;
  localparam int ADDR_W = 16;
  localparam int SIZE_W = 6;
  localparam int CNT_W  = 64;
  localparam int NVEC   = 14;

  // {is_instr, addr, size, expected l1 total, expected l2 total}
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b0, 16'h0000, 6'd4,  8'd1,  8'd1},  // R3 R4 cold miss
    {1'b0, 16'h0000, 6'd4,  8'd1,  8'd1},  // R3 hit
    {1'b1, 16'h0000, 6'd4,  8'd2,  8'd1},  // R2 separate side, L2 hit
    {1'b0, 16'h0008, 6'd16, 8'd3,  8'd1},  // R5 one line misses
    {1'b0, 16'h001C, 6'd8,  8'd4,  8'd2},  // R5 straddle both levels
    {1'b0, 16'h0F38, 6'd16, 8'd5,  8'd3},  // R5 both lines miss -> +1
    {1'b0, 16'h0F38, 6'd16, 8'd5,  8'd3},
    {1'b0, 16'h0040, 6'd1,  8'd6,  8'd4},  // R6 evicts least recent
    {1'b0, 16'h0000, 6'd1,  8'd7,  8'd4},
    {1'b0, 16'h0F40, 6'd1,  8'd8,  8'd4},
    {1'b0, 16'h0040, 6'd1,  8'd9,  8'd4},
    {1'b0, 16'h0F40, 6'd1,  8'd9,  8'd4},  // R6 hit promotes
    {1'b0, 16'h0080, 6'd1,  8'd10, 8'd5},
    {1'b0, 16'h0F40, 6'd1,  8'd10, 8'd5}   // R6 promoted line kept
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ref_valid = 1'b0;
  logic              ref_ready;
  logic [ADDR_W-1:0] ref_addr = '0;
  logic [SIZE_W-1:0] ref_size = '0;
  logic              ref_is_instr = 1'b0;
  logic              ref_err;
  logic [CNT_W-1:0]  l1_miss_cnt, l2_miss_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cache_miss_acct uut (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_addr(ref_addr), .ref_size(ref_size), .ref_is_instr(ref_is_instr),
    .ref_err(ref_err), .l1_miss_cnt(l1_miss_cnt), .l2_miss_cnt(l2_miss_cnt));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_counts(input string req, input longint e1, input longint e2);
    check(l1_miss_cnt == CNT_W'(e1), req, longint'(l1_miss_cnt), e1);
    check(l2_miss_cnt == CNT_W'(e2), req, longint'(l2_miss_cnt), e2);
  endtask

  // Offers one reference, returns the error flag seen the cycle after it is taken.
  task automatic send(input bit instr, input logic [ADDR_W-1:0] a,
                      input logic [SIZE_W-1:0] s, output bit err_seen);
    @(negedge clk);
    ref_valid = 1'b1; ref_addr = a; ref_size = s; ref_is_instr = instr;
    @(posedge clk);
    @(negedge clk);
    ref_valid = 1'b0;
    err_seen = ref_err;
    if (!err_seen) check(ref_ready == 1'b0, "R1 busy", ref_ready, 0);
    while (!ref_ready) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 / R1 reset state
    check(ref_ready == 1'b1, "R1 idle ready", ref_ready, 1);
    check(ref_err == 1'b0, "R8 err idle", ref_err, 0);
    check_counts("R9 reset", 0, 0);

    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][38], VEC[i][37:22], VEC[i][21:16], e);
      check(e == 1'b0, "R8 no err", e, 0);
      check_counts($sformatf("R3 R4 vec %0d", i), longint'(VEC[i][15:8]), longint'(VEC[i][7:0]));
    end

    // R7: size 0 is one byte; line 0xF4 present -> hit, no error
    send(1'b0, 16'h0F4F, 6'd0, e);
    check(e == 1'b0, "R7 size0 err", e, 0);
    check_counts("R7 size0", 10, 5);

    // R8: three-line reference refused, uncounted, directory untouched
    send(1'b1, 16'h0300, 6'd40, e);
    check(e == 1'b1, "R8 err pulse", e, 1);
    check(ref_ready == 1'b1, "R8 ready", ref_ready, 1);
    check_counts("R8 no count", 10, 5);
    @(negedge clk);
    check(ref_err == 1'b0, "R8 one cycle", ref_err, 0);
    send(1'b1, 16'h0300, 6'd1, e);
    check_counts("R8 no install", 11, 6);

    // R9: reset clears counters and directories
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check_counts("R9 clear", 0, 0);
    send(1'b0, 16'h0000, 6'd1, e);
    check_counts("R9 cold again", 1, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule